// File: doc/BRIEF.md
# Variable-Width Parallel CRC Engine

This block computes a cyclic redundancy check over a message that arrives as a series of chunks. Each chunk can hold a different number of bits. In each clock cycle the engine accepts a data word of `CRC_W` bits, where `CRC_W` is the degree of the generator polynomial, together with a count of how many of its leading bits belong to the message. It folds those bits into an `CRC_W`-bit remainder in a single step. The step XORs the current remainder with the new bits first, then runs one shared feedback network. The remainder does not go through one matrix and the input through another.

A user pulses `start_i` to begin a message. The user then presents chunks with `valid_i`, each with its bit count in `width_i`, and flags the final chunk with `last_i`. One cycle after the final chunk is absorbed, `done_o` pulses and `crc_o` holds the checksum of the whole message. That value equals what a one-bit-per-cycle shift register would produce over the same bits. The degree is chosen at elaboration from 12, 16, 24 and 32. No reflection and no final inversion are applied.

Top module: `crc_var_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, `crc_o` becomes 0 and `done_o` becomes 0.
- R2: A `start_i` cycle without `valid_i` leaves `crc_o` at 0 after that edge.
- R3: A chunk of n valid bits occupies `data_i[CRC_W-1 : CRC_W-n]`. Bit `CRC_W-1` is the first message bit. Bits below the chunk have no effect on `crc_o`.
- R4: For a message cut into chunks of any widths, `crc_o` after the last chunk equals a bit-serial LFSR computation over the whole message. That computation starts from 0 and shifts towards the MSB, message bit first.
- R5: A `valid_i` chunk with `width_i` = 0 leaves `crc_o` unchanged.
- R6: A `width_i` above `CRC_W` is treated as `CRC_W`.
- R7: `done_o` is 1 for exactly the cycle after the edge that absorbed a chunk with `last_i` = 1, and 0 otherwise.
- R8: After the last chunk, `crc_o` holds its value and `valid_i` chunks are ignored until the next `start_i`.
- R9: A cycle with both `start_i` and `valid_i` absorbs that chunk into a remainder of 0, as the first chunk of a new message.
- R10: The generator polynomial, without its top term, is 0x80F for degree 12, 0x8005 for degree 16, 0x864CFB for degree 24 and 0x04C11DB7 for degree 32. For degree 16, the ASCII message "123456789" gives 0xFEE8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new message; clears the remainder |
| valid_i | input | 1 | A chunk is present this cycle |
| last_i | input | 1 | The present chunk ends the message |
| width_i | input | $clog2(CRC_W+1) | Number of valid leading bits in `data_i` |
| data_i | input | CRC_W | Chunk bits, MSB-aligned |
| crc_o | output | CRC_W | Current remainder; final checksum after `done_o` |
| done_o | output | 1 | One-cycle pulse after the final chunk |

## Verification
On every cycle, the assertions check the following behaviours:
- a lone start clears the remainder;
- a zero-width chunk holds it;
- a closed message holds it;
- `done_o` is preceded by a final chunk.

The remaining behaviours cannot be expressed as a cycle-local property. These are the correctness of the merged XOR step, agreement with a serial LFSR across uneven chunk cuts, the masking of junk bits below the chunk, clamping of oversized widths, and the known check value. Only the bench scenarios show them: table vectors, random messages cut into random widths, and directed corner cases.

// File: rtl/crc_var_pkg.sv
// Package: shared constants for the variable-width CRC engine.
// Assumes the degree is one of 12, 16, 24, 32; any other degree maps to a zero polynomial.
package crc_var_pkg;

    // Generator polynomial without its top term, padded to 64 bits.
    function automatic logic [63:0] poly_for_degree(input int degree);
        case (degree)
            12:      return 64'h0000_0000_0000_080F;
            16:      return 64'h0000_0000_0000_8005;
            24:      return 64'h0000_0000_0086_4CFB;
            32:      return 64'h0000_0000_04C1_1DB7;
            default: return 64'h0;
        endcase
    endfunction

endpackage

// File: rtl/crc_chunk_align.sv
// Module: clamps the requested bit count to the degree and masks off the
// data bits below the chunk. Purely combinational.
// Assumes the chunk is MSB-aligned in data_i.
module crc_chunk_align #(
    parameter int CRC_W = 16,
    parameter int WW    = $clog2(CRC_W + 1)
) (
    input  logic [WW-1:0]    width_i,
    input  logic [CRC_W-1:0] data_i,
    output logic [WW-1:0]    count_o,
    output logic [CRC_W-1:0] bits_o
);

    logic [WW-1:0] cnt;

    // Clamp the count, then keep only the top cnt bits of the word.
    always_comb begin
        cnt = (int'(width_i) > CRC_W) ? WW'(CRC_W) : width_i;
        for (int j = 0; j < CRC_W; j++) begin
            bits_o[j] = data_i[j] & ((j + int'(cnt)) >= CRC_W);
        end
        count_o = cnt;
    end

endmodule

// File: rtl/crc_merged_step.sv
// Module: merged feedback/input update. The remainder and the aligned chunk
// are XORed first, then shifted count_i times through one feedback chain.
// Assumes count_i <= CRC_W and bits_i is zero below the chunk.
module crc_merged_step #(
    parameter int               CRC_W = 16,
    parameter int               WW    = $clog2(CRC_W + 1),
    parameter logic [CRC_W-1:0] POLY  = '0
) (
    input  logic [CRC_W-1:0] rem_i,
    input  logic [CRC_W-1:0] bits_i,
    input  logic [WW-1:0]    count_i,
    output logic [CRC_W-1:0] rem_o
);

    logic [CRC_W-1:0] acc;

    // Fold the input into the remainder, then run count_i gated shift stages.
    always_comb begin
        acc = rem_i ^ bits_i;
        for (int i = 0; i < CRC_W; i++) begin
            if (i < int'(count_i)) begin
                acc = {acc[CRC_W-2:0], 1'b0} ^ (acc[CRC_W-1] ? POLY : '0);
            end
        end
        rem_o = acc;
    end

endmodule

// File: rtl/crc_msg_ctrl.sv
// Module: message sequencing. Decides whether a chunk is absorbed, tracks
// whether the message is closed, and produces the one-cycle done pulse.
// Assumes synchronous active-low reset.
module crc_msg_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic valid_i,
    input  logic last_i,
    output logic accept_o,
    output logic closed_o,
    output logic done_o
);

    logic closed_q;
    logic done_q;

    // A chunk is taken when the message is open or a start reopens it.
    always_comb begin
        accept_o = valid_i && (start_i || !closed_q);
    end

    // Track the closed state and register the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            closed_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= accept_o && last_i;
            if (start_i) begin
                closed_q <= valid_i && last_i;
            end else if (accept_o && last_i) begin
                closed_q <= 1'b1;
            end
        end
    end

    assign closed_o = closed_q;
    assign done_o   = done_q;

    // done only follows a cycle that presented a final chunk
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_i && last_i));

endmodule

// File: rtl/crc_var_engine.sv
// Module: top of the variable-width parallel CRC engine.
// Absorbs up to CRC_W MSB-aligned bits per cycle into a CRC_W-bit remainder.
// The remainder starts from zero; no reflection and no final XOR are applied.
// Assumes CRC_W is 12, 16, 24 or 32; synchronous active-low reset.
module crc_var_engine #(
    parameter int CRC_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         valid_i,
    input  logic                         last_i,
    input  logic [$clog2(CRC_W+1)-1:0]   width_i,
    input  logic [CRC_W-1:0]             data_i,
    output logic [CRC_W-1:0]             crc_o,
    output logic                         done_o
);

    localparam int               WW        = $clog2(CRC_W + 1);
    localparam logic [63:0]      POLY_FULL = crc_var_pkg::poly_for_degree(CRC_W);
    localparam logic [CRC_W-1:0] POLY      = POLY_FULL[CRC_W-1:0];

    logic [WW-1:0]    count;
    logic [CRC_W-1:0] bits;
    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] rem_base;
    logic [CRC_W-1:0] rem_next;
    logic             accept;
    logic             closed;

    crc_chunk_align #(.CRC_W(CRC_W), .WW(WW)) u_align (
        .width_i (width_i),
        .data_i  (data_i),
        .count_o (count),
        .bits_o  (bits)
    );

    // A start makes the chunk begin from a zero remainder.
    always_comb begin
        rem_base = start_i ? '0 : rem_q;
    end

    crc_merged_step #(.CRC_W(CRC_W), .WW(WW), .POLY(POLY)) u_step (
        .rem_i   (rem_base),
        .bits_i  (bits),
        .count_i (count),
        .rem_o   (rem_next)
    );

    crc_msg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .valid_i  (valid_i),
        .last_i   (last_i),
        .accept_o (accept),
        .closed_o (closed),
        .done_o   (done_o)
    );

    // Remainder register: absorb, clear on start, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (accept) begin
            rem_q <= rem_next;
        end else if (start_i) begin
            rem_q <= '0;
        end
    end

    assign crc_o = rem_q;

    // a lone start clears the remainder
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_i) |=> (crc_o == '0));

    // a zero-width chunk leaves the remainder alone
    p_zero_width_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !start_i && (width_i == '0)) |=> $stable(crc_o));

    // a closed message is frozen until the next start
    p_closed_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (closed && !start_i) |=> $stable(crc_o));

endmodule

// File: tb/crc_var_engine_tb.sv
`timescale 1ns/1ps
module crc_var_engine_tb;

    localparam int W  = 16;
    localparam int WW = $clog2(W + 1);
    localparam logic [W-1:0] GEN = 16'h8005;

    typedef struct packed {
        logic [71:0]      msg;
        logic [7:0]       len;
        logic [7:0][4:0]  wl;
        logic [15:0]      exp;
        logic             use_exp;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{72'h31_3233_3435_3637_3839, 8'd72,
          '{0:5'd7, 1:5'd16, 2:5'd3, 3:5'd16, 4:5'd13, 5:5'd16, 6:5'd1, default:5'd16},
          16'hFEE8, 1'b1},
        '{72'hAB_CDEF_1234_5, 8'd48,
          '{0:5'd20, 1:5'd0, default:5'd16}, 16'h0, 1'b0},
        '{72'h1, 8'd1, '{default:5'd1}, 16'h8005, 1'b1},
        '{72'h2AAA_5555, 8'd30, '{default:5'd10}, 16'h0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          valid_i = 1'b0;
    logic          last_i = 1'b0;
    logic [WW-1:0] width_i = '0;
    logic [W-1:0]  data_i = '0;
    logic [W-1:0]  crc_o;
    logic          done_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    crc_var_engine #(.CRC_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .last_i(last_i), .width_i(width_i), .data_i(data_i),
        .crc_o(crc_o), .done_o(done_o)
    );

    function automatic logic [W-1:0] ref_crc(input logic [71:0] msg, input int len);
        logic [W-1:0] s = '0;
        for (int k = len - 1; k >= 0; k--) begin
            logic fb = s[W-1] ^ msg[k];
            s = {s[W-2:0], 1'b0} ^ (fb ? GEN : '0);
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input bit st, input bit vl, input bit ls, input int w, input logic [W-1:0] d);
        @(negedge clk);
        start_i = st; valid_i = vl; last_i = ls; width_i = WW'(w); data_i = d;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 0, '0);
    endtask

    // Send a whole message as chunks; wl gives widths, index >= 8 uses 16.
    task automatic send_msg(input logic [71:0] msg, input int len, input logic [7:0][4:0] wl,
                            input bit rand_w);
        int pos = len;
        int k = 0;
        drive(1'b1, 1'b0, 1'b0, 0, '0);
        while (pos > 0) begin
            int w;
            int eff;
            logic [W-1:0] word;
            w = rand_w ? int'($urandom_range(0, 20)) : ((k < 8) ? int'(wl[k]) : 16);
            eff = (w > W) ? W : w;
            if (eff > pos) begin
                w = pos;
                eff = pos;
            end
            word = W'($urandom);
            for (int b = 0; b < eff; b++) word[W-1-b] = msg[pos-1-b];
            pos -= eff;
            drive(1'b0, 1'b1, pos == 0, w, word);
            k++;
        end
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] hold;
        logic [W-1:0] exp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(crc_o == '0 && done_o == 1'b0, "R1 reset", {crc_o, 15'b0, done_o}, 32'h0);
        rst_n = 1'b1;

        // Table walk: R4 chunked equals serial, R10 check value, R6 via width 20
        for (int v = 0; v < 4; v++) begin
            send_msg(VECS[v].msg, int'(VECS[v].len), VECS[v].wl, 1'b0);
            exp = VECS[v].use_exp ? VECS[v].exp : ref_crc(VECS[v].msg, int'(VECS[v].len));
            check(crc_o == exp, (v == 0) ? "R10 check value" : "R4 table vector", crc_o, exp);
            check(done_o == 1'b1, "R7 done pulse", done_o, 1);
            @(negedge clk);
            check(done_o == 1'b0, "R7 done one cycle", done_o, 0);
        end

        // R4 and R3: random messages, random widths, random junk below chunk
        for (int n = 0; n < 20; n++) begin
            logic [71:0] m = {$urandom, $urandom, $urandom};
            int len = int'($urandom_range(1, 72));
            send_msg(m, len, '0, 1'b1);
            exp = ref_crc(m, len);
            check(crc_o == exp, "R4 random chunking", crc_o, exp);
        end

        // R8: a chunk after the last one is ignored
        hold = crc_o;
        drive(1'b0, 1'b1, 1'b1, 16, 16'hBEEF);
        idle();
        check(crc_o == hold, "R8 closed hold", crc_o, hold);
        check(done_o == 1'b0, "R8 no done when closed", done_o, 0);

        // R2: lone start clears
        drive(1'b1, 1'b0, 1'b0, 0, '0);
        idle();
        check(crc_o == '0, "R2 start clears", crc_o, 0);

        // R5: zero-width chunk holds mid-message
        drive(1'b0, 1'b1, 1'b0, 8, 16'hA5FF);
        drive(1'b0, 1'b1, 1'b0, 0, 16'hFFFF);
        hold = crc_o;
        idle();
        check(crc_o == hold, "R5 zero width", crc_o, hold);
        exp = ref_crc(72'hA5, 8);
        check(crc_o == exp, "R3 MSB first 8 bits", crc_o, exp);

        // R3: same chunk, different junk below it
        drive(1'b1, 1'b1, 1'b1, 5, 16'b10110_00000000000);
        idle();
        hold = crc_o;
        drive(1'b1, 1'b1, 1'b1, 5, 16'b10110_11111111111);
        idle();
        check(crc_o == hold, "R3 junk ignored", crc_o, hold);
        exp = ref_crc(72'b10110, 5);
        check(crc_o == exp, "R3 five bit chunk", crc_o, exp);

        // R6: width 31 acts as 16
        drive(1'b1, 1'b1, 1'b1, 31, 16'h1234);
        idle();
        exp = ref_crc(72'h1234, 16);
        check(crc_o == exp, "R6 clamp", crc_o, exp);

        // R9: start with valid on a nonzero remainder begins from zero
        drive(1'b1, 1'b1, 1'b1, 8, 16'h3100);
        idle();
        exp = ref_crc(72'h31, 8);
        check(crc_o == exp, "R9 start with chunk", crc_o, exp);
        check(done_o == 1'b1, "R9 done", done_o, 1);

        // R1: reset mid-message
        drive(1'b1, 1'b1, 1'b0, 16, 16'hFFFF);
        rst_n = 1'b0;
        idle();
        check(crc_o == '0 && done_o == 1'b0, "R1 reset mid message", crc_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule